// File: doc/BRIEF.md
# Programmable-Size Memory Address Decoder

This block sorts each bus request into one of four targets: a ROM window at the bottom of the address space, a RAM window at 0x0200_0000, a 256-byte control-register window at 0x01F8_0000, or a fault. The ROM and RAM windows have a fixed base and a maximum span (512 KB and 4 MB). Their populated size is set at run time by two 3-bit codes in a configuration register. A code `c` gives `MIN << c` bytes, and any code that would pass the maximum is held at the maximum. An address inside a window but beyond its populated size is a fault. So is an address outside every window, and so is an offset in the register window that holds no register. Faulting addresses never alias onto memory.

The block also holds a wait-count register. Memory accesses take the programmed number of extra cycles before ready. Register accesses and faults complete at once. A request is a single-cycle `req_valid` pulse, accepted only while the block is idle. The chip select for the target stays high from acceptance through the ready cycle. A fault raises `rsp_error` in the ready cycle and no select.

Top module: `mem_addr_decoder`

## Requirements
- R1: After reset, no select and no ready are asserted. The configuration register reads 0, which means 128 KB of ROM and 256 KB of RAM are populated. The wait register reads 0xFFF, which is 15 waits for every memory access class.
- R2: ROM populated size is 128 KB << code, where the ROM code is configuration bits [2:0]. Codes 2 to 7 all give 512 KB. A hit below that size asserts `rom_sel` and completes without error.
- R3: RAM populated size is 256 KB << code, where the RAM code is configuration bits [10:8]. Codes 4 to 7 all give 4 MB. A hit below that size asserts `ram_sel` and completes without error.
- R4: An address inside the ROM or RAM window but at or above the populated size completes with `rsp_error` high and no select.
- R5: In the register window, offset 0x10 (configuration) and offset 0x18 (wait counts) can be read and written, with reads returning the current value on `rsp_rdata` under `reg_sel`. Any other offset, and any address outside all windows, completes with `rsp_error`.
- R6: Configuration bits outside the two code fields are ignored. They read back as 0 and do not change decoding.
- R7: Wait-count fields are ROM in bits [3:0], RAM read in bits [7:4] and RAM write in bits [11:8]; higher bits are ignored and read as 0. With W waits, ready appears W cycles after the first cycle in which ready is possible.
- R8: Register and faulting accesses complete with zero waits, so ready comes in the cycle after acceptance.
- R9: `rsp_ready` is a one-cycle pulse per accepted request. `rsp_error` is high only in a ready cycle.
- R10: A `req_valid` pulse that arrives while an access is in progress is ignored. It produces no extra ready and does not change the selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data for register writes |
| rom_sel | output | 1 | ROM target selected for the current access |
| ram_sel | output | 1 | RAM target selected for the current access |
| reg_sel | output | 1 | Register window selected for the current access |
| rsp_ready | output | 1 | Access complete, one cycle |
| rsp_error | output | 1 | Access fault, together with ready |
| rsp_rdata | output | 32 | Register read data, valid with ready |

## Verification
A wrong size code shows up on the very next access near a window boundary. An address just below or just above the populated limit flips between a select and an error, so every size code is probed on both sides of its edge. A corrupted wait counter moves the ready cycle, and the scoreboard measures latency to the exact cycle against the programmed field. A busy flag stuck high or low shows within one access: it appears either as a missing ready or as an extra ready when a request overlaps an access in progress.

// File: rtl/dec_pkg.sv
package dec_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_ROM  = 2'd1,
      TGT_RAM  = 2'd2,
      TGT_REG  = 2'd3
   } tgt_e;
endpackage

// File: rtl/dec_window.sv
// Hit detection for one memory window whose populated size is MIN << code,
// limited to the window's full span.
module dec_window #(
   parameter int ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE = '0,
   parameter int MIN_LG = 17,
   parameter int MAX_LG = 19,
   parameter int CODE_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] code,
   output logic              hit
);
   localparam int LG_W     = $clog2(MAX_LG + 1);
   localparam int SPAN     = MAX_LG - MIN_LG;
   localparam int TOP_CODE = (1 << CODE_W) - 1;

   if (MAX_LG < MIN_LG || MAX_LG >= ADDR_W) begin : g_bad_span
      $error("dec_window: size range invalid");
   end
   if (BASE[MAX_LG-1:0] != '0) begin : g_bad_base
      $error("dec_window: base not aligned to full span");
   end

   logic [LG_W-1:0] size_lg;

   if (TOP_CODE <= SPAN) begin : g_direct
      assign size_lg = LG_W'(MIN_LG + int'(code));
   end else begin : g_clamp
      assign size_lg = (int'(code) > SPAN) ? LG_W'(MAX_LG)
                                           : LG_W'(MIN_LG + int'(code));
   end

   logic in_span;
   assign in_span = (addr[ADDR_W-1:MAX_LG] == BASE[ADDR_W-1:MAX_LG]);
   assign hit     = in_span && ((addr[MAX_LG-1:0] >> size_lg) == '0);
endmodule

// File: rtl/dec_cfg_regs.sv
// Size-code register and wait-count register.
module dec_cfg_regs #(
   parameter int DATA_W   = 32,
   parameter int CODE_W   = 3,
   parameter int WAIT_W   = 4,
   parameter int ROM_POS  = 0,
   parameter int RAM_POS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              wait_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CODE_W-1:0] rom_code,
   output logic [CODE_W-1:0] ram_code,
   output logic [WAIT_W-1:0] wt_rom,
   output logic [WAIT_W-1:0] wt_ram_rd,
   output logic [WAIT_W-1:0] wt_ram_wr,
   output logic [DATA_W-1:0] cfg_rd,
   output logic [DATA_W-1:0] wait_rd
);
   localparam int WREG_W = 3 * WAIT_W;

   if (WREG_W > DATA_W) begin : g_bad_wait
      $error("dec_cfg_regs: wait fields exceed data width");
   end
   if (ROM_POS + CODE_W > DATA_W || RAM_POS + CODE_W > DATA_W) begin : g_bad_pos
      $error("dec_cfg_regs: code field out of range");
   end
   if (ROM_POS < RAM_POS + CODE_W && RAM_POS < ROM_POS + CODE_W) begin : g_overlap
      $error("dec_cfg_regs: code fields overlap");
   end

   logic [WREG_W-1:0] wait_q;
   logic              unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_code <= '0;
         ram_code <= '0;
         wait_q   <= '1;
      end else begin
         if (cfg_we) begin
            rom_code <= wdata[ROM_POS +: CODE_W];
            ram_code <= wdata[RAM_POS +: CODE_W];
         end
         if (wait_we) wait_q <= wdata[WREG_W-1:0];
      end
   end

   assign wt_rom    = wait_q[0 +: WAIT_W];
   assign wt_ram_rd = wait_q[WAIT_W +: WAIT_W];
   assign wt_ram_wr = wait_q[2*WAIT_W +: WAIT_W];
   assign wait_rd   = DATA_W'(wait_q);

   always_comb begin
      cfg_rd = '0;
      cfg_rd[ROM_POS +: CODE_W] = rom_code;
      cfg_rd[RAM_POS +: CODE_W] = ram_code;
   end
endmodule

// File: rtl/dec_wait_ctrl.sv
// Access sequencer: idle until start, then counts down the loaded waits.
module dec_wait_ctrl #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WAIT_W-1:0] load,
   output logic              busy,
   output logic              ready
);
   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= load;
         end
      end else if (cnt == '0) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign ready = busy && (cnt == '0);
endmodule

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
   import dec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter logic [ADDR_W-1:0] ROM_BASE = 32'h0000_0000,
   parameter int ROM_MIN_LG = 17,
   parameter int ROM_MAX_LG = 19,
   parameter logic [ADDR_W-1:0] RAM_BASE = 32'h0200_0000,
   parameter int RAM_MIN_LG = 18,
   parameter int RAM_MAX_LG = 22,
   parameter logic [ADDR_W-1:0] REG_BASE = 32'h01F8_0000,
   parameter int REG_WIN_LG = 8,
   parameter int CODE_W     = 3,
   parameter int WAIT_W     = 4,
   parameter int ROM_POS    = 0,
   parameter int RAM_POS    = 8,
   parameter logic [REG_WIN_LG-1:0] CFG_OFS  = 8'h10,
   parameter logic [REG_WIN_LG-1:0] WAIT_OFS = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rom_sel,
   output logic              ram_sel,
   output logic              reg_sel,
   output logic              rsp_ready,
   output logic              rsp_error,
   output logic [DATA_W-1:0] rsp_rdata
);
   if (CFG_OFS == WAIT_OFS) begin : g_bad_ofs
      $error("mem_addr_decoder: register offsets collide");
   end
   if (REG_BASE[REG_WIN_LG-1:0] != '0) begin : g_bad_reg_base
      $error("mem_addr_decoder: register window misaligned");
   end

   logic [CODE_W-1:0] rom_code, ram_code;
   logic [WAIT_W-1:0] wt_rom, wt_ram_rd, wt_ram_wr, wt_load;
   logic [DATA_W-1:0] cfg_rd, wait_rd, rd_mux, rdata_q;
   logic rom_hit, ram_hit, reg_win, hit_cfg, hit_wait;
   logic busy, ready, accept;
   tgt_e tgt_d, tgt_q;

   dec_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .MIN_LG(ROM_MIN_LG),
                .MAX_LG(ROM_MAX_LG), .CODE_W(CODE_W))
      u_rom_win (.addr(req_addr), .code(rom_code), .hit(rom_hit));

   dec_window #(.ADDR_W(ADDR_W), .BASE(RAM_BASE), .MIN_LG(RAM_MIN_LG),
                .MAX_LG(RAM_MAX_LG), .CODE_W(CODE_W))
      u_ram_win (.addr(req_addr), .code(ram_code), .hit(ram_hit));

   assign reg_win  = (req_addr[ADDR_W-1:REG_WIN_LG] == REG_BASE[ADDR_W-1:REG_WIN_LG]);
   assign hit_cfg  = reg_win && (req_addr[REG_WIN_LG-1:0] == CFG_OFS);
   assign hit_wait = reg_win && (req_addr[REG_WIN_LG-1:0] == WAIT_OFS);
   assign accept   = req_valid && !busy;

   dec_cfg_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .WAIT_W(WAIT_W),
                  .ROM_POS(ROM_POS), .RAM_POS(RAM_POS))
      u_regs (.clk(clk), .rst_n(rst_n),
              .cfg_we(accept && req_write && hit_cfg),
              .wait_we(accept && req_write && hit_wait),
              .wdata(req_wdata), .rom_code(rom_code), .ram_code(ram_code),
              .wt_rom(wt_rom), .wt_ram_rd(wt_ram_rd), .wt_ram_wr(wt_ram_wr),
              .cfg_rd(cfg_rd), .wait_rd(wait_rd));

   always_comb begin
      if (rom_hit)                    tgt_d = TGT_ROM;
      else if (ram_hit)               tgt_d = TGT_RAM;
      else if (hit_cfg || hit_wait)   tgt_d = TGT_REG;
      else                            tgt_d = TGT_NONE;
      unique case (tgt_d)
         TGT_ROM: wt_load = wt_rom;
         TGT_RAM: wt_load = req_write ? wt_ram_wr : wt_ram_rd;
         default: wt_load = '0;
      endcase
      if (req_write)     rd_mux = '0;
      else if (hit_cfg)  rd_mux = cfg_rd;
      else if (hit_wait) rd_mux = wait_rd;
      else               rd_mux = '0;
   end

   dec_wait_ctrl #(.WAIT_W(WAIT_W))
      u_seq (.clk(clk), .rst_n(rst_n), .start(accept), .load(wt_load),
             .busy(busy), .ready(ready));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q   <= TGT_NONE;
         rdata_q <= '0;
      end else if (accept) begin
         tgt_q   <= tgt_d;
         rdata_q <= rd_mux;
      end
   end

   assign rom_sel   = busy && (tgt_q == TGT_ROM);
   assign ram_sel   = busy && (tgt_q == TGT_RAM);
   assign reg_sel   = busy && (tgt_q == TGT_REG);
   assign rsp_ready = ready;
   assign rsp_error = ready && (tgt_q == TGT_NONE);
   assign rsp_rdata = ready ? rdata_q : '0;
endmodule

// File: rtl/dec_checker.sv
module dec_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic rom_sel,
   input logic ram_sel,
   input logic reg_sel,
   input logic rsp_ready,
   input logic rsp_error
);
   logic any_sel;
   assign any_sel = rom_sel || ram_sel || reg_sel;

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_sel, ram_sel, reg_sel})); // R2
   AST_NO_SEL_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> !any_sel); // R4
   AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> busy); // R7
   AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> rsp_ready); // R9
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready); // R9
   AST_SEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !any_sel); // R9
   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rsp_ready) |=> $stable({rom_sel, ram_sel, reg_sel}) && busy); // R10
endmodule

bind mem_addr_decoder dec_checker u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy),
   .rom_sel(rom_sel), .ram_sel(ram_sel), .reg_sel(reg_sel),
   .rsp_ready(rsp_ready), .rsp_error(rsp_error)
);

// File: tb/tb_mem_addr_decoder.sv
`timescale 1ns/1ps
module tb_mem_addr_decoder;
   localparam logic [31:0] CFG_A  = 32'h01F8_0010;
   localparam logic [31:0] WAIT_A = 32'h01F8_0018;
   localparam int T_NONE = 0, T_ROM = 1, T_RAM = 2, T_REG = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic rom_sel, ram_sel, reg_sel, rsp_ready, rsp_error;
   logic [31:0] rsp_rdata;

   always #2 clk = ~clk;

   mem_addr_decoder dut (.*);

   typedef struct {
      int          tgt;
      bit          err;
      int          lat;
      logic [31:0] rdata;
      int          acc;
      string       tag;
   } exp_t;

   exp_t q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;

   always @(posedge clk) cyc++;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int sel_code();
      if (rom_sel) return T_ROM;
      if (ram_sel) return T_RAM;
      if (reg_sel) return T_REG;
      return T_NONE;
   endfunction

   // monitor
   always @(negedge clk) begin
      if (rst_n && rsp_ready) begin
         if (q.size() == 0) begin
            chk("R10", "unexpected ready", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "target", 32'(sel_code()), 32'(e.tgt));
            chk(e.tag, "error", 32'(rsp_error), 32'(e.err));
            chk(e.tag, "latency", 32'(cyc - e.acc), 32'(e.lat));
            chk(e.tag, "rdata", rsp_rdata, e.rdata);
         end
      end
   end

   task automatic push(bit wr, logic [31:0] a, logic [31:0] d, int tgt, bit err,
                       int lat, logic [31:0] rd, string tag);
      exp_t e;
      e.tgt = tgt; e.err = err; e.lat = lat; e.rdata = rd; e.acc = cyc + 1; e.tag = tag;
      q.push_back(e);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
   endtask

   task automatic access(bit wr, logic [31:0] a, logic [31:0] d, int tgt, bit err,
                         int lat, logic [31:0] rd, string tag);
      @(negedge clk);
      push(wr, a, d, tgt, err, lat, rd, tag);
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R9 watchdog: actual no completion expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "sel in reset", 32'({rom_sel, ram_sel, reg_sel}), 32'd0);
      chk("R1", "ready in reset", 32'(rsp_ready), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", 32'(rsp_ready), 32'd0);

      // reset defaults, zero-wait register reads (R1, R8)
      access(0, CFG_A, 0, T_REG, 0, 0, 32'h0, "R1");
      access(0, WAIT_A, 0, T_REG, 0, 0, 32'hFFF, "R1");
      // default sizes with 15 waits
      access(0, 32'h0001_FFFC, 0, T_ROM, 0, 15, 0, "R2");
      access(0, 32'h0002_0000, 0, T_NONE, 1, 0, 0, "R4");
      access(0, 32'h0203_FFFC, 0, T_RAM, 0, 15, 0, "R3");
      access(0, 32'h0204_0000, 0, T_NONE, 1, 0, 0, "R4");

      // wait register programming; upper bits ignored (R7)
      access(1, WAIT_A, 32'hFFFF_F321, T_REG, 0, 0, 0, "R7");
      access(0, WAIT_A, 0, T_REG, 0, 0, 32'h321, "R7");

      // foreign config bits ignored (R6)
      access(1, CFG_A, 32'hFFFF_F8F8, T_REG, 0, 0, 0, "R6");
      access(0, CFG_A, 0, T_REG, 0, 0, 32'h0, "R6");
      access(0, 32'h0002_0000, 0, T_NONE, 1, 0, 0, "R6");
      access(0, 32'h0001_0000, 0, T_ROM, 0, 1, 0, "R6");

      // full sizes: ROM code 2, RAM code 4
      access(1, CFG_A, 32'h0000_0402, T_REG, 0, 0, 0, "R5");
      access(0, CFG_A, 0, T_REG, 0, 0, 32'h402, "R5");
      access(0, 32'h0007_FFFC, 0, T_ROM, 0, 1, 0, "R2");
      access(1, 32'h0000_0100, 0, T_ROM, 0, 1, 0, "R7");
      access(0, 32'h0008_0000, 0, T_NONE, 1, 0, 0, "R5");
      access(1, 32'h023F_FFFC, 0, T_RAM, 0, 3, 0, "R7");
      access(0, 32'h023F_FFFC, 0, T_RAM, 0, 2, 0, "R7");
      access(0, 32'h0240_0000, 0, T_NONE, 1, 0, 0, "R5");

      // clamped top codes
      access(1, CFG_A, 32'h0000_0707, T_REG, 0, 0, 0, "R2");
      access(0, 32'h0007_FFFC, 0, T_ROM, 0, 1, 0, "R2");
      access(0, 32'h0008_0000, 0, T_NONE, 1, 0, 0, "R2");
      access(0, 32'h023F_FFFC, 0, T_RAM, 0, 2, 0, "R3");

      // middle codes: ROM 256 KB, RAM 1 MB
      access(1, CFG_A, 32'h0000_0201, T_REG, 0, 0, 0, "R4");
      access(0, 32'h0003_FFFC, 0, T_ROM, 0, 1, 0, "R2");
      access(0, 32'h0004_0000, 0, T_NONE, 1, 0, 0, "R4");
      access(0, 32'h020F_FFFC, 0, T_RAM, 0, 2, 0, "R3");
      access(0, 32'h0210_0000, 0, T_NONE, 1, 0, 0, "R4");

      // register window holes and unmapped space (R5, R8)
      access(0, 32'h01F8_0014, 0, T_NONE, 1, 0, 0, "R5");
      access(1, 32'h01F8_00FC, 32'h7, T_NONE, 1, 0, 0, "R5");
      access(0, 32'h01F8_0100, 0, T_NONE, 1, 0, 0, "R5");
      access(0, 32'h1000_0000, 0, T_NONE, 1, 0, 0, "R8");
      access(0, CFG_A, 0, T_REG, 0, 0, 32'h201, "R5");

      // request during busy ignored (R10)
      @(negedge clk);
      push(0, 32'h0200_0000, 0, T_RAM, 0, 2, 0, "R10");
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = CFG_A; req_wdata = 32'h0000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R10", "idle sel", 32'({rom_sel, ram_sel, reg_sel}), 32'd0);
      access(0, CFG_A, 0, T_REG, 0, 0, 32'h201, "R10");

      summary();
   end
endmodule